// File: doc/BRIEF.md
# Flash Write-Cycle Qualification Gate

This block stands between the chip-enable, write-enable and output-enable pins of a parallel NOR-style flash and its internal command state machine. It decides whether a bus cycle is a genuine write and passes it on only then. A cycle is released when four separate inhibit paths all allow it: the logical pin combination, a low-supply lockout flag from an external comparator, a power-up guard, and a pulse-width glitch filter on each control pin.

All three pin levels arrive already synchronized to the system clock and are active low. Each one passes through a deglitcher, which takes a new level only after that level has held for `MIN_PULSE` consecutive clock cycles. A controller with five named states follows the filtered levels. `ST_LOCK` is entered from reset and whenever `supply_low` is high, and it asserts `force_read`. `ST_WAIT_IDLE` counts `IDLE_CYC` consecutive cycles with write-enable high. `ST_IDLE` is armed and waits for a cycle to start. `ST_ACTIVE` is a cycle in progress. `ST_DRAIN` waits out a cycle that output-enable aborted.

The transitions are as follows. LOCK→WAIT_IDLE when the supply flag clears. WAIT_IDLE→IDLE when the idle count completes. IDLE→ACTIVE on the start condition. ACTIVE→IDLE with a commit on the first rise of write-enable or chip-enable. ACTIVE→DRAIN when output-enable goes low. DRAIN→IDLE once write-enable or chip-enable is high. Any state goes to LOCK while `supply_low` is high. A commit captures the address and data and emits a one-cycle `cmd_wr` strobe to the command logic.

Top module: `flash_wr_gate`

## Requirements
- R1: A cycle starts only while the filtered chip-enable and write-enable are both low (0) and output-enable is high (1); a valid cycle produces exactly one `cmd_wr` strobe.
- R2: Output-enable low, chip-enable high or write-enable high each blocks a write on its own; output-enable going low during a cycle aborts it without a strobe.
- R3: While `supply_low` is 1, no strobe is issued, and `force_read` is 1 from the cycle after `supply_low` is seen.
- R4: Complete write cycles made while `supply_low` stays 1 are ignored; after it clears, `force_read` drops one cycle later and writes are accepted again once the idle window has passed.
- R5: If chip-enable and write-enable are low with output-enable high when reset releases, the following rise of write-enable is not accepted.
- R6: During and after reset, `cmd_wr` is 0, `force_read` is 1, and `cmd_addr` and `cmd_data` are 0.
- R7: A pin level held for fewer than `MIN_PULSE` cycles has no effect; a write-enable low pulse of exactly `MIN_PULSE` cycles is accepted.
- R8: A write commits on whichever of write-enable or chip-enable rises first and captures `bus_addr` and `bus_data` at that moment. `cmd_wr` is high in the cycle `MIN_PULSE`+1 clock edges after the raw rise, with `cmd_addr` and `cmd_data` valid alongside it.
- R9: After reset or lockout, `IDLE_CYC` consecutive cycles with write-enable high must pass before a cycle can start; an attempt made earlier is ignored.
- R10: `cmd_wr` is never high for two cycles in a row.
- R11: A cycle ended by chip-enable rising, with write-enable still held low, is committed in the same way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| ce_n | input | 1 | Synchronized chip-enable level, active low |
| we_n | input | 1 | Synchronized write-enable level, active low |
| oe_n | input | 1 | Synchronized output-enable level, active low |
| supply_low | input | 1 | Low-supply lockout flag |
| bus_addr | input | ADDR_W | Address on the pins |
| bus_data | input | DATA_W | Data on the pins |
| cmd_wr | output | 1 | One-cycle qualified write strobe |
| cmd_addr | output | ADDR_W | Address latched at commit |
| cmd_data | output | DATA_W | Data latched at commit |
| force_read | output | 1 | Holds the command logic in read mode |

## Verification
The assertions assume that the pin levels and `supply_low` are already synchronous to `clk` and are driven to known values from time zero. The stimulus changes every input only on the falling clock edge. The address and data latch takes the values present at the commit cycle, which comes `MIN_PULSE` cycles after the raw edge. The bench therefore keeps `bus_addr` and `bus_data` steady for several cycles after each rising write-enable or chip-enable. Pin pulses are chosen to fall below, at, and well above `MIN_PULSE`, so that the deglitcher property sees both rejected and accepted levels.

// File: rtl/flash_wr_gate_pkg.sv
package flash_wr_gate_pkg;
    typedef enum logic [2:0] {
        ST_LOCK,
        ST_WAIT_IDLE,
        ST_IDLE,
        ST_ACTIVE,
        ST_DRAIN
    } fwg_state_e;
endpackage

// File: rtl/fwg_deglitch.sv
module fwg_deglitch #(
    parameter int   MIN_PULSE = 3,
    parameter logic RST_LVL   = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    localparam int CW = (MIN_PULSE > 1) ? $clog2(MIN_PULSE) : 1;

    generate
        if (MIN_PULSE <= 1) begin : g_pass
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) filt <= RST_LVL;
                else        filt <= raw;
            end
        end else begin : g_count
            logic [CW-1:0] cnt;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    filt <= RST_LVL;
                    cnt  <= '0;
                end else if (raw == filt) begin
                    cnt <= '0;
                end else if (cnt == CW'(MIN_PULSE - 1)) begin
                    filt <= raw;
                    cnt  <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    endgenerate

    // R7: a new filtered level must match the raw level seen on the previous edge
    assert_filter_settled_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (filt != $past(filt)) |-> (filt == $past(raw)));
endmodule

// File: rtl/fwg_ctrl.sv
module fwg_ctrl
    import flash_wr_gate_pkg::*;
#(
    parameter int IDLE_CYC = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_f,
    input  logic we_f,
    input  logic oe_f,
    input  logic supply_low,
    output logic commit,
    output logic cmd_wr,
    output logic force_read
);
    localparam int ICW = (IDLE_CYC > 1) ? $clog2(IDLE_CYC + 1) : 1;

    fwg_state_e    state, nxt;
    logic [ICW-1:0] idle_cnt;

    // state register and idle-window counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_LOCK;
            idle_cnt <= '0;
        end else begin
            state <= nxt;
            if (state == ST_WAIT_IDLE && we_f && !supply_low) idle_cnt <= idle_cnt + 1'b1;
            else                                              idle_cnt <= '0;
        end
    end

    // next-state and commit decision
    always_comb begin
        nxt    = state;
        commit = 1'b0;
        unique case (state)
            ST_LOCK:      if (!supply_low) nxt = ST_WAIT_IDLE;
            ST_WAIT_IDLE: if (we_f && idle_cnt == ICW'(IDLE_CYC - 1)) nxt = ST_IDLE;
            ST_IDLE:      if (!ce_f && !we_f && oe_f) nxt = ST_ACTIVE;
            ST_ACTIVE: begin
                if (!oe_f) begin
                    nxt = ST_DRAIN;
                end else if (we_f || ce_f) begin
                    nxt    = ST_IDLE;
                    commit = 1'b1;
                end
            end
            ST_DRAIN:     if (we_f || ce_f) nxt = ST_IDLE;
            default:      nxt = ST_LOCK;
        endcase
        if (supply_low) begin
            nxt    = ST_LOCK;
            commit = 1'b0;
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_wr     <= 1'b0;
            force_read <= 1'b1;
        end else begin
            cmd_wr     <= commit;
            force_read <= (nxt == ST_LOCK);
        end
    end

    assert_stb_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |=> !cmd_wr);
    assert_lock_blocks_R3: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |=> (!cmd_wr && force_read));
    assert_oe_inhibit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> $past(oe_f));
    assert_commit_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> ((we_f || ce_f) && $past(!we_f && !ce_f)));
    assert_stb_not_locked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr |-> !force_read);
endmodule

// File: rtl/fwg_latch.sv
module fwg_latch #(
    parameter int ADDR_W = 18,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] a_in,
    input  logic [DATA_W-1:0] d_in,
    output logic [ADDR_W-1:0] a_q,
    output logic [DATA_W-1:0] d_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            a_q <= '0;
            d_q <= '0;
        end else if (load) begin
            a_q <= a_in;
            d_q <= d_in;
        end
    end

    // R8: captured values change only on a commit
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(load) |-> ($stable(a_q) && $stable(d_q)));
endmodule

// File: rtl/flash_wr_gate.sv
module flash_wr_gate #(
    parameter int ADDR_W    = 18,
    parameter int DATA_W    = 16,
    parameter int MIN_PULSE = 3,
    parameter int IDLE_CYC  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              supply_low,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_data,
    output logic              cmd_wr,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              force_read
);
    localparam int NPIN = 3;

    logic [NPIN-1:0] pin_raw, pin_filt;
    logic            commit;

    assign pin_raw = {oe_n, we_n, ce_n};

    generate
        for (genvar i = 0; i < NPIN; i++) begin : g_pin
            fwg_deglitch #(.MIN_PULSE(MIN_PULSE), .RST_LVL(1'b1)) u_dg (
                .clk (clk),
                .rst_n(rst_n),
                .raw (pin_raw[i]),
                .filt(pin_filt[i])
            );
        end
    endgenerate

    fwg_ctrl #(.IDLE_CYC(IDLE_CYC)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_f      (pin_filt[0]),
        .we_f      (pin_filt[1]),
        .oe_f      (pin_filt[2]),
        .supply_low(supply_low),
        .commit    (commit),
        .cmd_wr    (cmd_wr),
        .force_read(force_read)
    );

    fwg_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk  (clk),
        .rst_n(rst_n),
        .load (commit),
        .a_in (bus_addr),
        .d_in (bus_data),
        .a_q  (cmd_addr),
        .d_q  (cmd_data)
    );
endmodule

// File: tb/sim_flash_wr_gate.sv
`timescale 1ns/1ps
module sim_flash_wr_gate;
    localparam int AW = 18, DW = 16, MINP = 3, IDLE = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, supply_low = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [DW-1:0] bus_data = '0;
    logic cmd_wr, force_read;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;

    int checks = 0, failures = 0, nstb = 0;
    bit done = 1'b0;
    logic [AW+DW-1:0] expq[$];

    always #2 clk = ~clk;

    flash_wr_gate #(.ADDR_W(AW), .DATA_W(DW), .MIN_PULSE(MINP), .IDLE_CYC(IDLE)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .supply_low(supply_low), .bus_addr(bus_addr), .bus_data(bus_data),
        .cmd_wr(cmd_wr), .cmd_addr(cmd_addr), .cmd_data(cmd_data), .force_read(force_read));

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // monitor: pops the scoreboard on every strobe
    always @(negedge clk) begin
        if (rst_n && cmd_wr) begin
            nstb++;
            if (expq.size() == 0) begin
                check(1'b0, "R1 unexpected strobe", {cmd_addr, cmd_data}, 0);
            end else begin
                logic [AW+DW-1:0] e;
                e = expq.pop_front();
                check({cmd_addr, cmd_data} == e, "R8 captured addr/data", {cmd_addr, cmd_data}, e);
            end
        end
    end

    // cycle ended by write-enable rising
    task automatic wr_we(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit ok);
        int n0;
        n0 = nstb;
        bus_addr = a; bus_data = d; ce_n = 1'b0;
        tick(2); we_n = 1'b0;
        tick(6); we_n = 1'b1;
        if (ok) expq.push_back({a, d});
        tick(MINP);
        if (ok) check(cmd_wr == 1'b0, "R8 no strobe before latency", cmd_wr, 0);
        tick(1);
        if (ok) check(cmd_wr == 1'b1, "R8 strobe at latency", cmd_wr, 1);
        tick(1);
        if (ok) check(cmd_wr == 1'b0, "R10 single cycle", cmd_wr, 0);
        tick(3); ce_n = 1'b1;
        tick(6);
        check(nstb - n0 == (ok ? 1 : 0), ok ? "R1 one strobe" : "R9/R4 ignored", nstb - n0, ok ? 1 : 0);
    endtask

    task automatic no_strobe(input int n0, input string req);
        check(nstb == n0, req, nstb, n0);
    endtask

    initial begin
        int n0;
        // R6 reset state
        tick(3);
        check(cmd_wr == 1'b0, "R6 strobe in reset", cmd_wr, 0);
        check(force_read == 1'b1, "R6 force_read in reset", force_read, 1);
        check(cmd_addr == '0 && cmd_data == '0, "R6 latch in reset", {cmd_addr, cmd_data}, 0);
        rst_n = 1'b1;
        tick(1);
        check(force_read == 1'b0, "R6 force_read after reset", force_read, 0);
        // R9 attempt inside the idle window
        wr_we(18'h00011, 16'h1111, 1'b0);
        tick(IDLE + 4);
        // R1 and R8 valid writes with varied patterns
        wr_we(18'h3FFFF, 16'hFFFF, 1'b1);
        wr_we(18'h00000, 16'h0000, 1'b1);
        wr_we(18'h2A5A5, 16'h5AA5, 1'b1);
        // R11 chip-enable ends the cycle
        n0 = nstb;
        bus_addr = 18'h12345; bus_data = 16'hBEEF;
        we_n = 1'b0; tick(2); ce_n = 1'b0; tick(6); ce_n = 1'b1;
        expq.push_back({18'h12345, 16'hBEEF});
        tick(MINP + 1);
        check(cmd_wr == 1'b1, "R11 strobe on chip-enable rise", cmd_wr, 1);
        tick(4); we_n = 1'b1; tick(6);
        check(nstb - n0 == 1, "R11 one strobe", nstb - n0, 1);
        // R2 output-enable low throughout
        n0 = nstb;
        oe_n = 1'b0; ce_n = 1'b0; tick(2); we_n = 1'b0; tick(6); we_n = 1'b1; tick(6); ce_n = 1'b1; oe_n = 1'b1; tick(6);
        no_strobe(n0, "R2 output-enable low blocks");
        // R2 output-enable drops during a cycle
        ce_n = 1'b0; tick(2); we_n = 1'b0; tick(6); oe_n = 1'b0; tick(6); oe_n = 1'b1; tick(2);
        we_n = 1'b1; tick(8); ce_n = 1'b1; tick(6);
        no_strobe(n0, "R2 abort on output-enable");
        // R2 chip-enable high, write-enable toggled
        we_n = 1'b0; tick(6); we_n = 1'b1; tick(8);
        no_strobe(n0, "R2 chip-enable high blocks");
        // R7 short pulse rejected, boundary pulse accepted
        ce_n = 1'b0; tick(2); we_n = 1'b0; tick(MINP - 1); we_n = 1'b1; tick(10);
        no_strobe(n0, "R7 short pulse ignored");
        bus_addr = 18'h0BEAD; bus_data = 16'hC0DE; expq.push_back({18'h0BEAD, 16'hC0DE});
        we_n = 1'b0; tick(MINP); we_n = 1'b1; tick(10); ce_n = 1'b1; tick(4);
        check(nstb - n0 == 1, "R7 pulse of minimum width accepted", nstb - n0, 1);
        // R3 lockout during a cycle
        n0 = nstb;
        ce_n = 1'b0; tick(2); we_n = 1'b0; tick(6);
        supply_low = 1'b1; tick(1);
        check(force_read == 1'b1, "R3 force_read on lockout", force_read, 1);
        we_n = 1'b1; tick(10); ce_n = 1'b1; tick(4);
        no_strobe(n0, "R3 no strobe in lockout");
        // R4 complete cycle while locked
        wr_we(18'h00777, 16'h7777, 1'b0);
        check(force_read == 1'b1, "R4 force_read held", force_read, 1);
        supply_low = 1'b0; tick(1);
        check(force_read == 1'b0, "R4 force_read released", force_read, 0);
        tick(IDLE + 4);
        wr_we(18'h01234, 16'h4321, 1'b1);
        // R5 power-up with a cycle already in progress
        n0 = nstb;
        rst_n = 1'b0; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1; tick(3);
        rst_n = 1'b1; tick(10);
        we_n = 1'b1; tick(IDLE + 8);
        no_strobe(n0, "R5 first rise after power-up ignored");
        ce_n = 1'b1; tick(6);
        wr_we(18'h15555, 16'hAAAA, 1'b1);
        check(expq.size() == 0, "R1 scoreboard drained", expq.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule